// File: doc/BRIEF.md
# Oscillator Frequency Change Sequencer

This block retunes an external programmable oscillator by issuing register writes over a two-wire serial bus. A request carries the new high-speed divider code, the output divider code and the 38-bit frequency word. The sequencer then runs four write transactions in a fixed order. The first sets the core freeze bit. The second writes all dividers and the frequency word in one burst. The third clears the freeze bit. The fourth sets the new-frequency strobe bit. While the output clock recovers, it holds a reset request towards downstream logic, and it then reports completion with a one-cycle done pulse and an error code.

The bus itself is handled by a separate byte-level engine. The sequencer gives that engine one command at a time (start condition, write byte, stop condition). It waits for the engine's response, which carries the target's acknowledge for written bytes, before it issues the next command. A byte that is not acknowledged aborts the sequence through a stop condition. A strobe that lands too late after the unfreeze write is also reported as an error.

Top module: `osc_reprog_seq`

## Requirements
- R1: After reset, busy, done, osc_rst_req and cmd_valid are all 0 and err_code is 0.
- R2: An accepted request produces exactly four write transactions in the order freeze, configure, unfreeze, strobe. Each transaction is a start command, its write bytes and a stop command, and each command is issued only after the response to the previous one.
- R3: The first byte of every transaction is the device address in bits 7:1 with bit 0 = 0 (write), and the second byte is the target register number.
- R4: The configure transaction addresses register CFG_REG (default 7) and sends six data bytes. Byte 0 is {hs[2:0], n1[6:2]}, byte 1 is {n1[1:0], rfreq[37:32]}, and bytes 2 to 5 are rfreq[31:0], most significant byte first.
- R5: The freeze transaction writes a byte with only bit FRZ_BIT set (default bit 4, value 0x10) to FRZ_REG (default 137). The unfreeze transaction writes 0x00 to the same register. Freeze precedes and unfreeze follows every divider and frequency-word byte.
- R6: The strobe transaction writes 0x40 (bit 6 set) to register 135, and it is issued only after the unfreeze transaction has completed.
- R7: If more than NF_LIMIT cycles pass between the response to the unfreeze stop and the response to the strobe data byte, the stop is still issued, done pulses with err_code = 2, and osc_rst_req never rises.
- R8: On success, osc_rst_req is high for exactly SETTLE_CYC consecutive cycles after the strobe stop completes. done pulses in the first cycle after osc_rst_req falls, with err_code = 0.
- R9: A write byte answered without acknowledge is followed directly by a stop command, with no further bytes or transactions. done then pulses with err_code = 1 and osc_rst_req never rises.
- R10: busy is high from the cycle after a request is accepted until done. Requests presented while busy are ignored: they change no command and start no later sequence.
- R11: done lasts one cycle and coincides with the first cycle in which busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Change request, accepted when idle |
| req_hs | input | 3 | New high-speed divider code |
| req_n1 | input | 7 | New output divider code |
| req_rfreq | input | 38 | New frequency word |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 2 | 0 ok, 1 missing acknowledge, 2 strobe deadline missed |
| osc_rst_req | output | 1 | Downstream reset request during settling |
| cmd_valid | output | 1 | One-cycle command to the bus engine |
| cmd_op | output | 2 | 0 start, 1 write byte, 2 read byte (unused), 3 stop |
| cmd_data | output | 8 | Byte to write (0 for start and stop) |
| rsp_valid | input | 1 | Engine finished the pending command |
| rsp_ack | input | 1 | Target acknowledged the written byte |

## Verification
busy rises in the first cycle after the edge that takes the request, and each new command appears one cycle after the edge that consumes the previous response. After a missing acknowledge, the very next command must be a stop. osc_rst_req is due in the cycle after the strobe stop response and must last SETTLE_CYC cycles, and done is due in the first cycle after osc_rst_req falls, or right after the final stop response on an abort. The bench drives and samples on falling edges, counts the reset-request cycles between those points, and its bus model checks each command against a queue of expected commands at the moment it is observed.

// File: rtl/osc_reprog_pkg.sv
// Shared encodings for the oscillator change sequencer.
// Assumes: command op codes are agreed with the byte-level bus engine.
package osc_reprog_pkg;
    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_STOP  = 2'd3
    } bus_op_e;

    typedef enum logic [1:0] {
        ERR_NONE = 2'd0,
        ERR_NACK = 2'd1,
        ERR_LATE = 2'd2
    } seq_err_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_BYTE, ST_STOP, ST_SETTLE
    } seq_state_e;

    localparam logic [1:0] TXN_FREEZE = 2'd0;
    localparam logic [1:0] TXN_CONFIG = 2'd1;
    localparam logic [1:0] TXN_THAW   = 2'd2;
    localparam logic [1:0] TXN_STROBE = 2'd3;

    typedef struct packed {
        logic [2:0]  hs;
        logic [6:0]  n1;
        logic [37:0] rfreq;
    } osc_cfg_t;
endpackage

// File: rtl/osc_reprog_payload.sv
// Byte source: gives the byte at position idx of transaction txn and
// flags the last one. Position 0 is the address byte, 1 the register.
// Assumes: idx never passes the last position of its transaction.
module osc_reprog_payload
    import osc_reprog_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h55,
    parameter logic [7:0] CFG_REG  = 8'd7,
    parameter logic [7:0] FRZ_REG  = 8'd137,
    parameter int unsigned FRZ_BIT = 4,
    parameter logic [7:0] NF_REG   = 8'd135,
    parameter int unsigned NF_BIT  = 6
) (
    input  logic [1:0] txn,
    input  logic [3:0] idx,
    input  osc_cfg_t   cfg,
    output logic [7:0] byte_o,
    output logic       last_o
);
    localparam logic [7:0] FRZ_MASK = 8'(1) << FRZ_BIT;
    localparam logic [7:0] NF_MASK  = 8'(1) << NF_BIT;

    logic [47:0] cfg_flat;
    logic [47:0] cfg_shift;
    logic [2:0]  sel;

    // Select the byte for the current position.
    always_comb begin
        cfg_flat  = cfg;
        sel       = 3'(idx - 4'd2);
        cfg_shift = cfg_flat << {sel, 3'b000};
        byte_o    = 8'h00;
        if (idx == 4'd0) begin
            byte_o = {DEV_ADDR, 1'b0};
        end else if (idx == 4'd1) begin
            case (txn)
                TXN_CONFIG: byte_o = CFG_REG;
                TXN_STROBE: byte_o = NF_REG;
                default:    byte_o = FRZ_REG;
            endcase
        end else begin
            case (txn)
                TXN_FREEZE: byte_o = FRZ_MASK;
                TXN_CONFIG: byte_o = cfg_shift[47:40];
                TXN_STROBE: byte_o = NF_MASK;
                default:    byte_o = 8'h00;
            endcase
        end
    end

    // Last position: 8 bytes for the configure burst, 3 otherwise.
    always_comb last_o = (txn == TXN_CONFIG) ? (idx == 4'd7) : (idx == 4'd2);
endmodule

// File: rtl/osc_reprog_timer.sv
// Saturating up-counter with synchronous clear.
// Assumes: clr has priority over run.
module osc_reprog_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         run,
    output logic [W-1:0] cnt
);
    // Count while running, hold at all ones.
    always_ff @(posedge clk) begin
        if (!rst_n)                           cnt <= '0;
        else if (clr)                         cnt <= '0;
        else if (run && (cnt != {W{1'b1}}))   cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/osc_reprog_seq.sv
// Oscillator change sequencer: freeze, configure, unfreeze, strobe, settle.
// Issues one bus command at a time and waits for its response.
// Assumes: the bus engine answers each command exactly once with rsp_valid.
module osc_reprog_seq
    import osc_reprog_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR   = 7'h55,
    parameter logic [7:0] CFG_REG    = 8'd7,
    parameter logic [7:0] FRZ_REG    = 8'd137,
    parameter int unsigned FRZ_BIT   = 4,
    parameter logic [7:0] NF_REG     = 8'd135,
    parameter int unsigned NF_BIT    = 6,
    parameter int unsigned SETTLE_CYC = 500000,
    parameter int unsigned NF_LIMIT   = 500
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [2:0]  req_hs,
    input  logic [6:0]  req_n1,
    input  logic [37:0] req_rfreq,
    output logic        busy,
    output logic        done,
    output logic [1:0]  err_code,
    output logic        osc_rst_req,
    output logic        cmd_valid,
    output logic [1:0]  cmd_op,
    output logic [7:0]  cmd_data,
    input  logic        rsp_valid,
    input  logic        rsp_ack
);
    localparam int unsigned SET_W = $clog2(SETTLE_CYC + 1);
    localparam int unsigned NF_W  = $clog2(NF_LIMIT + 2);

    seq_state_e       state;
    logic             pend;
    logic [1:0]       txn;
    logic [3:0]       idx;
    osc_cfg_t         cfg_q;
    logic             abort_q;
    logic [1:0]       err_q;
    logic             done_q;
    logic             nf_run;
    logic [7:0]       pay_byte;
    logic             pay_last;
    logic [SET_W-1:0] set_cnt;
    logic [NF_W-1:0]  nf_cnt;
    logic             stop_fire;
    logic             set_clr;
    logic             nf_clr;
    logic             settle_end;

    osc_reprog_payload #(
        .DEV_ADDR(DEV_ADDR), .CFG_REG(CFG_REG), .FRZ_REG(FRZ_REG),
        .FRZ_BIT(FRZ_BIT), .NF_REG(NF_REG), .NF_BIT(NF_BIT)
    ) u_pay (
        .txn(txn), .idx(idx), .cfg(cfg_q), .byte_o(pay_byte), .last_o(pay_last)
    );

    osc_reprog_timer #(.W(SET_W)) u_settle (
        .clk(clk), .rst_n(rst_n), .clr(set_clr), .run(state == ST_SETTLE), .cnt(set_cnt)
    );

    osc_reprog_timer #(.W(NF_W)) u_deadline (
        .clk(clk), .rst_n(rst_n), .clr(nf_clr), .run(nf_run), .cnt(nf_cnt)
    );

    // Timer controls and status decode.
    always_comb begin
        stop_fire  = (state == ST_STOP) && pend && rsp_valid && !abort_q;
        set_clr    = stop_fire && (txn == TXN_STROBE);
        nf_clr     = stop_fire && (txn == TXN_THAW);
        settle_end = (state == ST_SETTLE) && (set_cnt == SET_W'(SETTLE_CYC - 1));
    end

    // Command port drive.
    always_comb begin
        cmd_valid = ((state == ST_START) || (state == ST_BYTE) || (state == ST_STOP)) && !pend;
        cmd_op    = OP_START;
        cmd_data  = 8'h00;
        if (state == ST_BYTE) begin
            cmd_op   = OP_WRITE;
            cmd_data = pay_byte;
        end else if (state == ST_STOP) begin
            cmd_op = OP_STOP;
        end
    end

    assign busy        = (state != ST_IDLE);
    assign done        = done_q;
    assign err_code    = err_q;
    assign osc_rst_req = (state == ST_SETTLE);

    // Main sequencing state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            pend    <= 1'b0;
            txn     <= TXN_FREEZE;
            idx     <= 4'd0;
            cfg_q   <= '0;
            abort_q <= 1'b0;
            err_q   <= ERR_NONE;
            done_q  <= 1'b0;
            nf_run  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: if (req_valid) begin
                    cfg_q   <= '{hs: req_hs, n1: req_n1, rfreq: req_rfreq};
                    txn     <= TXN_FREEZE;
                    idx     <= 4'd0;
                    abort_q <= 1'b0;
                    err_q   <= ERR_NONE;
                    nf_run  <= 1'b0;
                    pend    <= 1'b0;
                    state   <= ST_START;
                end
                ST_START: begin
                    if (!pend) pend <= 1'b1;
                    else if (rsp_valid) begin
                        pend  <= 1'b0;
                        idx   <= 4'd0;
                        state <= ST_BYTE;
                    end
                end
                ST_BYTE: begin
                    if (!pend) pend <= 1'b1;
                    else if (rsp_valid) begin
                        pend <= 1'b0;
                        if (!rsp_ack) begin
                            abort_q <= 1'b1;
                            err_q   <= ERR_NACK;
                            state   <= ST_STOP;
                        end else begin
                            if ((txn == TXN_STROBE) && pay_last) begin
                                nf_run <= 1'b0;
                                if (nf_cnt > NF_W'(NF_LIMIT)) begin
                                    abort_q <= 1'b1;
                                    err_q   <= ERR_LATE;
                                end
                            end
                            if (pay_last) state <= ST_STOP;
                            else          idx   <= idx + 4'd1;
                        end
                    end
                end
                ST_STOP: begin
                    if (!pend) pend <= 1'b1;
                    else if (rsp_valid) begin
                        pend <= 1'b0;
                        if (abort_q) begin
                            state  <= ST_IDLE;
                            done_q <= 1'b1;
                        end else if (txn == TXN_STROBE) begin
                            state <= ST_SETTLE;
                        end else begin
                            if (txn == TXN_THAW) nf_run <= 1'b1;
                            txn   <= txn + 2'd1;
                            state <= ST_START;
                        end
                    end
                end
                ST_SETTLE: if (settle_end) begin
                    state  <= ST_IDLE;
                    done_q <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/osc_reprog_chk.sv
// Port-level properties of the oscillator change sequencer.
// Assumes: bound to every instance of osc_reprog_seq.
module osc_reprog_chk
    import osc_reprog_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic [1:0] err_code,
    input logic       osc_rst_req,
    input logic       cmd_valid,
    input logic [1:0] cmd_op,
    input logic       rsp_valid,
    input logic       rsp_ack
);
    logic [1:0] last_op;
    logic       wait_rsp;

    // Track the outstanding command as seen at the port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_op  <= OP_START;
            wait_rsp <= 1'b0;
        end else if (cmd_valid) begin
            last_op  <= cmd_op;
            wait_rsp <= 1'b1;
        end else if (rsp_valid) begin
            wait_rsp <= 1'b0;
        end
    end

    AST_CMD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> busy); // R10
    AST_SETTLE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        osc_rst_req |-> busy); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_DONE_AT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R11
    AST_ERR_NO_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (err_code != 2'd0)) |-> !$past(osc_rst_req)); // R9
    AST_NACK_TO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_rsp && rsp_valid && !rsp_ack && (last_op == OP_WRITE))
        |=> (cmd_valid && (cmd_op == OP_STOP))); // R9
endmodule

bind osc_reprog_seq osc_reprog_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err_code(err_code),
    .osc_rst_req(osc_rst_req), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .rsp_valid(rsp_valid), .rsp_ack(rsp_ack)
);

// File: tb/osc_reprog_seq_tb_top.sv
module osc_reprog_seq_tb_top;
    localparam int SETTLE = 25;
    localparam int LIMIT  = 40;
    localparam logic [6:0] ADDR = 7'h55;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_hs = '0;
    logic [6:0]  req_n1 = '0;
    logic [37:0] req_rfreq = '0;
    logic        busy, done, osc_rst_req, cmd_valid;
    logic [1:0]  err_code, cmd_op;
    logic [7:0]  cmd_data;
    logic        rsp_valid = 1'b0;
    logic        rsp_ack = 1'b0;

    int errs = 0;
    int checks = 0;
    int cmd_idx = 0;
    int nack_at = -1;
    int slow_from = 1000;
    int rst_cycles = 0;
    logic prev_rst = 1'b0;
    logic [9:0] exp_q[$];
    string stream_tag = "R2 R3 R4 R5 R6";

    always #10 clk = ~clk;

    osc_reprog_seq #(.DEV_ADDR(ADDR), .SETTLE_CYC(SETTLE), .NF_LIMIT(LIMIT)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_hs(req_hs),
        .req_n1(req_n1), .req_rfreq(req_rfreq), .busy(busy), .done(done),
        .err_code(err_code), .osc_rst_req(osc_rst_req), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_data(cmd_data), .rsp_valid(rsp_valid), .rsp_ack(rsp_ack)
    );

    task automatic check(input logic ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Driver side of the scoreboard: expected command items.
    task automatic push_op(input logic [1:0] op, input logic [7:0] d);
        exp_q.push_back({op, d});
    endtask

    task automatic push_hdr(input logic [7:0] regn);
        push_op(2'd0, 8'h00);
        push_op(2'd1, {ADDR, 1'b0});
        push_op(2'd1, regn);
    endtask

    task automatic push_full(input logic [2:0] hs, input logic [6:0] n1, input logic [37:0] rf);
        push_hdr(8'd137); push_op(2'd1, 8'h10); push_op(2'd3, 8'h00);
        push_hdr(8'd7);
        push_op(2'd1, {hs, n1[6:2]});
        push_op(2'd1, {n1[1:0], rf[37:32]});
        push_op(2'd1, rf[31:24]); push_op(2'd1, rf[23:16]);
        push_op(2'd1, rf[15:8]);  push_op(2'd1, rf[7:0]);
        push_op(2'd3, 8'h00);
        push_hdr(8'd137); push_op(2'd1, 8'h00); push_op(2'd3, 8'h00);
        push_hdr(8'd135); push_op(2'd1, 8'h40); push_op(2'd3, 8'h00);
    endtask

    // Monitor side: bus engine model that pops and compares each command.
    initial begin
        forever begin
            @(negedge clk);
            rsp_valid = 1'b0;
            if (cmd_valid) begin
                logic [9:0] e;
                int lat;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10", "unexpected command", {cmd_op, cmd_data}, 0);
                end else begin
                    e = exp_q.pop_front();
                    check(cmd_op == e[9:8], stream_tag, "command op", cmd_op, e[9:8]);
                    if (e[9:8] == 2'd1)
                        check(cmd_data == e[7:0], stream_tag, "write byte", cmd_data, e[7:0]);
                end
                lat = (cmd_idx >= slow_from) ? 30 : 2;
                rsp_ack = (cmd_idx != nack_at);
                cmd_idx++;
                repeat (lat) @(negedge clk);
                rsp_valid = 1'b1;
            end
        end
    end

    task automatic start_req(input logic [2:0] hs, input logic [6:0] n1, input logic [37:0] rf);
        cmd_idx = 0;
        @(negedge clk);
        req_hs = hs; req_n1 = n1; req_rfreq = rf; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy == 1'b1, "R10", "busy after accept", busy, 1);
    endtask

    task automatic wait_done();
        int n = 0;
        rst_cycles = 0;
        prev_rst = 1'b0;
        forever begin
            @(negedge clk);
            if (done) break;
            if (osc_rst_req) rst_cycles++;
            prev_rst = osc_rst_req;
            n++;
            if (n > 20000) begin
                check(1'b0, "R11", "watchdog waiting for done", 0, 1);
                break;
            end
        end
        check(busy == 1'b0, "R11", "busy low with done", busy, 0);
    endtask

    task automatic after_done();
        @(negedge clk);
        check(done == 1'b0, "R11", "done one cycle", done, 0);
        check(exp_q.size() == 0, "R2", "leftover expected commands", exp_q.size(), 0);
        repeat (5) @(negedge clk);
        check(!busy && !cmd_valid, "R10", "no restart after done", busy, 0);
    endtask

    task automatic good_run(input logic [2:0] hs, input logic [6:0] n1, input logic [37:0] rf,
                            input logic poke);
        push_full(hs, n1, rf);
        start_req(hs, n1, rf);
        if (poke) begin
            repeat (4) @(negedge clk);
            req_hs = ~hs; req_n1 = ~n1; req_rfreq = ~rf; req_valid = 1'b1;
            repeat (3) @(negedge clk);
            req_valid = 1'b0;
        end
        wait_done();
        check(rst_cycles == SETTLE, "R8", "reset request length", rst_cycles, SETTLE);
        check(prev_rst == 1'b1, "R8", "done right after settle", prev_rst, 1);
        check(err_code == 2'd0, "R8", "error code ok", err_code, 0);
        after_done();
    endtask

    // Global watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R1", "global watchdog", 0, 1);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done && !osc_rst_req && !cmd_valid, "R1", "idle outputs in reset", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !osc_rst_req && !cmd_valid, "R1", "idle after reset", busy, 0);
        check(err_code == 2'd0, "R1", "err after reset", err_code, 0);

        // Main function, with a request poked while busy.
        good_run(3'b000, 7'h07, 38'h07FA611E85, 1'b1);
        good_run(3'b101, 7'h7F, 38'h2A5555AAAA, 1'b0);

        // Missing acknowledge on the configure register byte.
        stream_tag = "R9";
        nack_at = 7;
        push_hdr(8'd137); push_op(2'd1, 8'h10); push_op(2'd3, 8'h00);
        push_hdr(8'd7); push_op(2'd3, 8'h00);
        start_req(3'b010, 7'h11, 38'h1234567890);
        wait_done();
        check(err_code == 2'd1, "R9", "nack error code", err_code, 1);
        check(rst_cycles == 0, "R9", "no reset request", rst_cycles, 0);
        after_done();
        nack_at = -1;

        // Strobe deadline missed.
        stream_tag = "R7";
        slow_from = 20;
        push_full(3'b001, 7'h03, 38'h3F00FF00FF);
        start_req(3'b001, 7'h03, 38'h3F00FF00FF);
        wait_done();
        check(err_code == 2'd2, "R7", "late strobe code", err_code, 2);
        check(rst_cycles == 0, "R7", "no reset request", rst_cycles, 0);
        after_done();
        slow_from = 1000;

        // Normal again after errors.
        stream_tag = "R2 R4";
        good_run(3'b111, 7'h40, 38'h0000000001, 1'b0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule